// File: doc/BRIEF.md
# Partitioned Command FIFO with Debug Peek

This block holds queued command words for several channels in one shared storage array. Each channel owns a circular window of that array, set by a programmable first entry (base) and last entry (limit). A producer pushes words into a chosen channel and a consumer pops them in order. Each channel keeps its own write and read pointers. Both pointers wrap from the limit back to the base.

A simple register port gives access to the window setup of each channel, to a per-channel status word with an empty flag, and to a debug peek path. The peek path selects a channel and any absolute entry index. When peek is enabled, the peek path returns the stored word and the selected channel's pointers. Peeking never moves a pointer, so a stalled channel can be inspected in place. Register reads return data in the cycle after the read strobe.

Top module: `cmd_fifo_peek`

## Requirements
- R1: After reset every window setup, every pointer and the peek control word are zero. Every channel reports empty. `popValid` and `regRData` are 0.
- R2: The setup word of channel c is at register address 0x00+c. Its base is in bits 8:0 and its limit in bits 24:16, and it reads back as written with the other bits zero. Writing it sets both pointers of channel c to the new base.
- R3: The status word of channel c is at address 0x10+c. Bit 10 is 1 exactly when the channel's read and write pointers are equal, and every other bit is 0.
- R4: An accepted push stores `pushData` at the channel's write pointer and then advances that pointer. A pointer equal to its limit advances to its base; otherwise it increments by one. Other channels are not affected. `pushAccept` is only ever high together with `pushValid`.
- R5: A push is refused (`pushAccept` low in the same cycle) when advancing the write pointer would make it equal to the read pointer. A refused push changes no pointer.
- R6: A pop on a non-empty channel raises `popValid` in the next cycle with the word at the read pointer, and advances the read pointer by the R4 wrap rule. A pop on an empty channel leaves `popValid` low and changes nothing.
- R7: The peek control word is at address 0x20, with enable in bit 31, channel in bits 18:16 and entry index in bits 8:0. A read of address 0x21 while enable is 1 returns the word stored at that index.
- R8: While the peek enable is 0, a read of address 0x21 returns zero.
- R9: A read of address 0x22 returns the peek-selected channel's read pointer in bits 8:0 and its write pointer in bits 24:16. It returns zero for a channel number that is not implemented.
- R10: Peek reads and pointer reads leave every pointer unchanged.
- R11: `regRData` is valid in the cycle after `regRdEn` and is 0 in every other cycle. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push request |
| pushChan | input | CH_W | Channel to push into |
| pushData | input | DATA_W | Word to push |
| pushAccept | output | 1 | Push taken this cycle |
| popReq | input | 1 | Pop request |
| popChan | input | CH_W | Channel to pop from |
| popValid | output | 1 | Popped word valid (cycle after request) |
| popData | output | DATA_W | Popped word |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Register word address |
| regWData | input | 32 | Register write data |
| regRData | output | 32 | Register read data (cycle after strobe) |

## Verification
On every cycle the assertions check these relations: a push is never accepted without a request, a popped word only follows a pop request, read data is zero outside the cycle after a read strobe, and a peek read with the enable off returns zero. The following can only be shown by the bench's scenarios against its own model of windows, pointers and storage: wrap from limit to base, refusal of a push into a full window, window rewrites resetting the pointers, the content that a peek returns, and the pointers being left untouched after peeks.

// File: rtl/cmdfifo_pkg.sv
package cmdfifo_pkg;
  localparam int IDX_W  = 9;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  typedef logic [IDX_W-1:0] idx_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    idx_t wrAddr;
    logic rdEn;
    idx_t rdAddr;
    logic peekEn;
    idx_t peekAddr;
  } dp_strobe_t;

  localparam logic [3:0]        SETUP_PAGE  = 4'h0;
  localparam logic [3:0]        STATUS_PAGE = 4'h1;
  localparam logic [ADDR_W-1:0] PEEK_CTRL   = 8'h20;
  localparam logic [ADDR_W-1:0] PEEK_DATA   = 8'h21;
  localparam logic [ADDR_W-1:0] PEEK_PTRS   = 8'h22;

  localparam logic [REG_W-1:0] SETUP_MASK = 32'h01FF_01FF;
  localparam logic [REG_W-1:0] PEEK_MASK  = 32'h8007_01FF;
  localparam int PEEK_EN_BIT = 31;
  localparam int EMPTY_BIT   = 10;

  function automatic idx_t advance(idx_t p, idx_t base, idx_t limit);
    return (p == limit) ? base : idx_t'(p + 1'b1);
  endfunction
endpackage

// File: rtl/cmdfifo_dpath.sv
module cmdfifo_dpath
  import cmdfifo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] pushData,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  output logic [DATA_W-1:0] peekWord
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[strobe.wrAddr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      popValid <= 1'b0;
      popData  <= '0;
      peekWord <= '0;
    end else begin
      popValid <= strobe.rdEn;
      if (strobe.rdEn) popData <= store[strobe.rdAddr];
      peekWord <= strobe.peekEn ? store[strobe.peekAddr] : '0;
    end
  end
endmodule

// File: rtl/cmdfifo_ctrl.sv
module cmdfifo_ctrl
  import cmdfifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [CH_W-1:0]   pushChan,
  input  logic              popReq,
  input  logic [CH_W-1:0]   popChan,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWData,
  output logic              pushAccept,
  output dp_strobe_t        strobe,
  output logic [REG_W-1:0]  ctrlRdQ
);
  logic [REG_W-1:0] setupV [NUM_CH];
  idx_t             wrV    [NUM_CH];
  idx_t             rdV    [NUM_CH];
  logic [NUM_CH-1:0] chEmpty, chFull;

  logic [REG_W-1:0] peekCtrlQ;
  logic [2:0]       peekCh;
  logic             pushFire, popFire;
  logic             selFull, selEmpty;
  idx_t             selWr, selRd, peekRd, peekWr;
  logic [REG_W-1:0] rdVal;

  assign peekCh = peekCtrlQ[18:16];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [REG_W-1:0] setupR;
    idx_t wrR, rdR, baseW, limitW;
    logic setupHit, pushHit, popHit;

    assign baseW    = setupR[8:0];
    assign limitW   = setupR[24:16];
    assign setupHit = regWrEn && (regAddr == {SETUP_PAGE, 4'(g)});
    assign pushHit  = pushFire && (pushChan == CH_W'(g));
    assign popHit   = popFire && (popChan == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        setupR <= '0;
        wrR    <= '0;
        rdR    <= '0;
      end else if (setupHit) begin
        setupR <= regWData & SETUP_MASK;
        wrR    <= regWData[8:0];
        rdR    <= regWData[8:0];
      end else begin
        if (pushHit) wrR <= advance(wrR, baseW, limitW);
        if (popHit)  rdR <= advance(rdR, baseW, limitW);
      end
    end

    assign setupV[g]  = setupR;
    assign wrV[g]     = wrR;
    assign rdV[g]     = rdR;
    assign chEmpty[g] = (wrR == rdR);
    assign chFull[g]  = (advance(wrR, baseW, limitW) == rdR);
  end

  always_comb begin
    selFull  = 1'b1;
    selEmpty = 1'b1;
    selWr    = '0;
    selRd    = '0;
    peekRd   = '0;
    peekWr   = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pushChan == CH_W'(i)) begin
        selFull = chFull[i];
        selWr   = wrV[i];
      end
      if (popChan == CH_W'(i)) begin
        selEmpty = chEmpty[i];
        selRd    = rdV[i];
      end
      if (peekCh == 3'(i)) begin
        peekRd = rdV[i];
        peekWr = wrV[i];
      end
    end
  end

  assign pushFire   = pushValid && !selFull;
  assign popFire    = popReq && !selEmpty;
  assign pushAccept = pushFire;

  always_comb begin
    strobe.wrEn     = pushFire;
    strobe.wrAddr   = selWr;
    strobe.rdEn     = popFire;
    strobe.rdAddr   = selRd;
    strobe.peekEn   = regRdEn && (regAddr == PEEK_DATA) && peekCtrlQ[PEEK_EN_BIT];
    strobe.peekAddr = peekCtrlQ[8:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) peekCtrlQ <= '0;
    else if (regWrEn && regAddr == PEEK_CTRL) peekCtrlQ <= regWData & PEEK_MASK;
  end

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == {SETUP_PAGE, 4'(i)})  rdVal = setupV[i];
      if (regAddr == {STATUS_PAGE, 4'(i)}) rdVal = REG_W'(chEmpty[i]) << EMPTY_BIT;
    end
    if (regAddr == PEEK_CTRL) rdVal = peekCtrlQ;
    if (regAddr == PEEK_PTRS) rdVal = {7'b0, peekWr, 7'b0, peekRd};
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlRdQ <= '0;
    else       ctrlRdQ <= regRdEn ? rdVal : '0;
  end
endmodule

// File: rtl/cmd_fifo_peek.sv
module cmd_fifo_peek
  import cmdfifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [CH_W-1:0]   pushChan,
  input  logic [DATA_W-1:0] pushData,
  output logic              pushAccept,
  input  logic              popReq,
  input  logic [CH_W-1:0]   popChan,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWData,
  output logic [31:0]       regRData
);
  dp_strobe_t        strobe;
  logic [REG_W-1:0]  ctrlRdQ;
  logic [DATA_W-1:0] peekWord;

  cmdfifo_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushChan(pushChan),
    .popReq(popReq), .popChan(popChan),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWData(regWData),
    .pushAccept(pushAccept), .strobe(strobe), .ctrlRdQ(ctrlRdQ)
  );

  cmdfifo_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(pushData),
    .popValid(popValid), .popData(popData), .peekWord(peekWord)
  );

  assign regRData = ctrlRdQ | REG_W'(peekWord);
endmodule

// File: rtl/cmdfifo_checker.sv
module cmdfifo_checker (
  input logic        clk,
  input logic        rstN,
  input logic        pushValid,
  input logic        pushAccept,
  input logic        popReq,
  input logic        popValid,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [7:0]  regAddr,
  input logic [31:0] regWData,
  input logic [31:0] regRData
);
  logic enShadow, offRdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enShadow <= 1'b0;
      offRdQ   <= 1'b0;
    end else begin
      if (regWrEn && regAddr == 8'h20) enShadow <= regWData[31];
      offRdQ <= regRdEn && regAddr == 8'h21 && !enShadow;
    end
  end

  assert_accept_needs_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    pushAccept |-> pushValid);

  assert_pop_after_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> $past(popReq));

  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regRdEn) |-> regRData == 32'h0);

  assert_peek_off_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    offRdQ |-> regRData == 32'h0);
endmodule

bind cmd_fifo_peek cmdfifo_checker u_chk (.*);

// File: tb/tb_cmd_fifo_peek.sv
`timescale 1ns/1ps
module tb_cmd_fifo_peek;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 1'b0;
  logic [1:0]  pushChan = '0;
  logic [31:0] pushData = '0;
  logic        pushAccept;
  logic        popReq = 1'b0;
  logic [1:0]  popChan = '0;
  logic        popValid;
  logic [31:0] popData;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmd_fifo_peek #(.NUM_CH(NCH), .DATA_W(32)) dut (.*);

  // Reference model
  logic [31:0] mMem [512];
  bit          mWritten [512];
  logic [8:0]  mBase [NCH], mLimit [NCH], mWr [NCH], mRd [NCH];
  logic [31:0] mPeekCtrl;

  function automatic logic [8:0] mAdv(logic [8:0] p, int ch);
    return (p == mLimit[ch]) ? mBase[ch] : 9'(p + 1);
  endfunction
  function automatic bit mEmpty(int ch);
    return mWr[ch] == mRd[ch];
  endfunction
  function automatic bit mFull(int ch);
    return mAdv(mWr[ch], ch) == mRd[ch];
  endfunction
  function automatic logic [31:0] expPtrs(int ch);
    return {7'b0, mWr[ch], 7'b0, mRd[ch]};
  endfunction
  function automatic logic [31:0] expStatus(int ch);
    return mEmpty(ch) ? 32'h400 : 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWData = d;
    @(posedge clk); #1;
    regWrEn = 0;
    if (a[7:4] == 4'h0 && a[3:0] < 4'(NCH)) begin
      mBase[a[1:0]] = d[8:0]; mLimit[a[1:0]] = d[24:16];
      mWr[a[1:0]] = d[8:0];   mRd[a[1:0]] = d[8:0];
    end
    if (a == 8'h20) mPeekCtrl = d & 32'h8007_01FF;
  endtask

  task automatic regRd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    regRdEn = 1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 0;
    chk(tag, regRData, exp);
  endtask

  task automatic doPush(int ch, logic [31:0] d, string tag);
    bit expAcc;
    expAcc = !mFull(ch);
    @(negedge clk);
    pushValid = 1; pushChan = 2'(ch); pushData = d;
    #1 chk(tag, {31'b0, pushAccept}, {31'b0, expAcc});
    @(posedge clk); #1;
    pushValid = 0;
    if (expAcc) begin
      mMem[mWr[ch]] = d; mWritten[mWr[ch]] = 1; mWr[ch] = mAdv(mWr[ch], ch);
    end
  endtask

  task automatic doPop(int ch, string tag);
    bit expV;
    logic [31:0] expD;
    expV = !mEmpty(ch);
    expD = mMem[mRd[ch]];
    @(negedge clk);
    popReq = 1; popChan = 2'(ch);
    @(posedge clk); #1;
    popReq = 0;
    chk(tag, {31'b0, popValid}, {31'b0, expV});
    if (expV) begin
      chk(tag, popData, expD);
      mRd[ch] = mAdv(mRd[ch], ch);
    end
  endtask

  task automatic readPtrs(int ch, string tag);
    regWr(8'h20, {1'b1, 12'b0, 3'(ch), 7'b0, 9'h0});
    regRd(8'h22, expPtrs(ch), tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NCH; i++) begin
      mBase[i] = 0; mLimit[i] = 0; mWr[i] = 0; mRd[i] = 0;
    end
    for (int i = 0; i < 512; i++) begin mMem[i] = 0; mWritten[i] = 0; end
    mPeekCtrl = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state
    chk("R1 popValid", {31'b0, popValid}, 32'h0);
    chk("R1 regRData", regRData, 32'h0);
    regRd(8'h10, 32'h400, "R1 status ch0 empty");
    regRd(8'h01, 32'h0, "R1 setup ch1");
    regRd(8'h20, 32'h0, "R1 peek ctrl");
    regRd(8'h22, 32'h0, "R1 ptrs");

    // R2: window setup
    regWr(8'h00, {7'h7F, 9'd7, 7'h7F, 9'd0});
    regWr(8'h01, {7'b0, 9'd11, 7'b0, 9'd8});
    regWr(8'h02, {7'b0, 9'd115, 7'b0, 9'd100});
    regWr(8'h03, {7'b0, 9'd202, 7'b0, 9'd200});
    regRd(8'h00, 32'h0007_0000, "R2 setup ch0 masked readback");
    regRd(8'h02, 32'h0073_0064, "R2 setup ch2 readback");
    readPtrs(2, "R2 pointers at base");

    // R5: ch3 holds two words
    doPush(3, 32'hA000_0001, "R4 push ch3 first");
    doPush(3, 32'hA000_0002, "R4 push ch3 second");
    doPush(3, 32'hA000_0003, "R5 push ch3 refused when full");
    readPtrs(3, "R5 pointers unchanged after refusal");
    regRd(8'h13, 32'h0, "R3 ch3 not empty");
    regRd(8'h10, 32'h400, "R4 ch0 untouched by ch3 pushes");

    // R8 / R7 / R9 / R10: peek
    regWr(8'h20, {1'b0, 12'b0, 3'd3, 7'b0, 9'd200});
    regRd(8'h21, 32'h0, "R8 peek disabled reads zero");
    regWr(8'h20, {1'b1, 12'b0, 3'd3, 7'b0, 9'd201});
    regRd(8'h20, 32'h8003_00C9, "R7 peek ctrl readback");
    regRd(8'h21, 32'hA000_0002, "R7 peek data at 201");
    regRd(8'h22, expPtrs(3), "R9 ptrs of ch3");
    regRd(8'h21, 32'hA000_0002, "R10 repeated peek");
    regRd(8'h22, expPtrs(3), "R10 ptrs unchanged after peek");
    regWr(8'h20, {1'b1, 12'b0, 3'd6, 7'b0, 9'd0});
    regRd(8'h22, 32'h0, "R9 unimplemented channel ptrs zero");

    // R6: pops and empty pop
    doPop(3, "R6 pop ch3 first");
    doPop(3, "R6 pop ch3 second");
    doPop(3, "R6 pop on empty refused");
    regRd(8'h13, 32'h400, "R3 ch3 empty again");

    // R4: wrap from limit to base
    doPush(3, 32'hB000_0001, "R4 push at limit");
    readPtrs(3, "R4 write pointer wrapped to base");
    doPush(3, 32'hB000_0002, "R4 push after wrap");
    doPop(3, "R4 pop at limit");
    doPop(3, "R4 pop wrapped word");

    // R11: unmapped reads
    regRd(8'h30, 32'h0, "R11 unmapped address");
    regRd(8'h15, 32'h0, "R11 status of absent channel");

    // R2: rewrite resets pointers
    doPush(3, 32'hC000_0001, "R4 push before rewrite");
    regWr(8'h03, {7'b0, 9'd215, 7'b0, 9'd210});
    readPtrs(3, "R2 rewrite resets pointers to base");
    regRd(8'h13, 32'h400, "R2 empty after rewrite");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op, ch;
      op = $urandom_range(0, 6);
      ch = $urandom_range(0, NCH - 1);
      case (op)
        0, 1, 2: doPush(ch, $urandom, "R4/R5 random push");
        3:       doPop(ch, "R6 random pop");
        4:       regRd(8'(8'h10 + ch), expStatus(ch), "R3 random status");
        5: begin
          logic [8:0] a;
          a = mRd[ch];
          if (mWritten[a]) begin
            regWr(8'h20, {1'b1, 12'b0, 3'(ch), 7'b0, a});
            regRd(8'h21, mMem[a], "R7 random peek");
          end else begin
            regWr(8'h20, {1'b0, 12'b0, 3'(ch), 7'b0, a});
            regRd(8'h21, 32'h0, "R8 random disabled peek");
          end
          regRd(8'h22, expPtrs(ch), "R10 random ptrs after peek");
        end
        default: readPtrs(ch, "R9 random ptrs");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule